// File: doc/BRIEF.md
# Four-Port Arbitrated Integer Calculator

This block gives four independent requesters shared use of one 32-bit arithmetic unit. Each requester has its own command input and operand input, and its own response output and result output. A requester starts an operation by placing a command code on its command input together with the first operand. On the following cycle it places the second operand on the same operand input. The block stores both operands per port. A round-robin arbiter then hands the shared unit to one ready port per cycle. The outcome returns on the issuing port as a one-cycle response code with its result.

Each port holds at most one command at a time. The response code tells success apart from an add carry-out, a subtract borrow and an unknown command. Any command code that arrives while its port is still busy is dropped.

Top module: `quad_port_calc`

## Requirements
- R1: Command code 1 (add) returns the low 32 bits of operand1 + operand2 with response code 1 (success) when the sum fits in 32 bits, including a sum of exactly 0xFFFFFFFF.
- R2: An add whose true sum exceeds 0xFFFFFFFF, including by exactly one, returns response code 2 with the wrapped low 32 bits.
- R3: Command code 2 (subtract) returns operand1 - operand2 with response code 1 when operand2 <= operand1; equal operands give zero.
- R4: A subtract with operand2 > operand1 (unsigned), for example operand2 = operand1 + 1, returns response code 2 with the wrapped 32-bit difference.
- R5: Command code 5 shifts operand1 left and code 6 shifts it right logically, by operand2[4:0] places (0 to 31), with response code 1.
- R6: Command codes 3, 4 and 7 to 15 return response code 3 (invalid) with result 0.
- R7: Command code 0 is a no-op and produces no response on any port.
- R8: Operand1 is taken in the cycle the command is presented and operand2 in the next cycle. An uncontested response appears three cycles after the command cycle and lasts exactly one cycle. The result output is 0 whenever the response code is 0 (none).
- R9: A response appears only on the port that issued the command; every other port keeps response code 0.
- R10: When several ports are ready together, one is served per cycle in round-robin order, starting from the port after the one served last, so at most one port responds in any cycle.
- R11: A nonzero command code presented on a port that already holds a command is ignored.
- R12: A synchronous reset drops all held commands, clears all outputs to 0, and makes port 0 the first in the round-robin order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd0_i | input | 4 | Port 0 command code |
| cmd1_i | input | 4 | Port 1 command code |
| cmd2_i | input | 4 | Port 2 command code |
| cmd3_i | input | 4 | Port 3 command code |
| opnd0_i | input | DW | Port 0 operand (operand1, then operand2 on the next cycle) |
| opnd1_i | input | DW | Port 1 operand |
| opnd2_i | input | DW | Port 2 operand |
| opnd3_i | input | DW | Port 3 operand |
| rsp0_o | output | 2 | Port 0 response: 0 none, 1 ok, 2 overflow/underflow, 3 invalid |
| rsp1_o | output | 2 | Port 1 response |
| rsp2_o | output | 2 | Port 2 response |
| rsp3_o | output | 2 | Port 3 response |
| res0_o | output | DW | Port 0 result |
| res1_o | output | DW | Port 1 result |
| res2_o | output | DW | Port 2 result |
| res3_o | output | DW | Port 3 result |

## Verification
Round-robin order only shows when several ports become ready in the same cycle, with the last-served pointer at a known position. The stimulus therefore issues commands on all four ports, or on a chosen pair, in the same cycle. It does this right after a single-port command on a chosen port, and right after a reset, so that each wrap-around of the pointer is reached. It then checks cycle by cycle which port answers. Dropped commands are reached by holding the command input nonzero through the operand2 cycle and the wait cycle.

// File: rtl/quad_port_calc.sv
module quad_port_calc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cmd0_i,
  input  logic [3:0]    cmd1_i,
  input  logic [3:0]    cmd2_i,
  input  logic [3:0]    cmd3_i,
  input  logic [DW-1:0] opnd0_i,
  input  logic [DW-1:0] opnd1_i,
  input  logic [DW-1:0] opnd2_i,
  input  logic [DW-1:0] opnd3_i,
  output logic [1:0]    rsp0_o,
  output logic [1:0]    rsp1_o,
  output logic [1:0]    rsp2_o,
  output logic [1:0]    rsp3_o,
  output logic [DW-1:0] res0_o,
  output logic [DW-1:0] res1_o,
  output logic [DW-1:0] res2_o,
  output logic [DW-1:0] res3_o
);
  localparam int NP = 4;
  localparam int SW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_OP2, S_RDY} st_t;

  logic [3:0]    cmd_in [NP];
  logic [DW-1:0] opd_in [NP];
  st_t           st     [NP];
  logic [3:0]    pc     [NP];
  logic [DW-1:0] pa     [NP];
  logic [DW-1:0] pb     [NP];
  logic [1:0]    rsp_q  [NP];
  logic [DW-1:0] res_q  [NP];
  logic [NP-1:0] rdy;
  logic [1:0]    last, gidx;
  logic          gval;

  assign cmd_in[0] = cmd0_i;  assign opd_in[0] = opnd0_i;
  assign cmd_in[1] = cmd1_i;  assign opd_in[1] = opnd1_i;
  assign cmd_in[2] = cmd2_i;  assign opd_in[2] = opnd2_i;
  assign cmd_in[3] = cmd3_i;  assign opd_in[3] = opnd3_i;

  assign rsp0_o = rsp_q[0];  assign res0_o = res_q[0];
  assign rsp1_o = rsp_q[1];  assign res1_o = res_q[1];
  assign rsp2_o = rsp_q[2];  assign res2_o = res_q[2];
  assign rsp3_o = rsp_q[3];  assign res3_o = res_q[3];

  always_comb begin
    gval = 1'b0;
    gidx = last;
    for (int k = 1; k <= NP; k++) begin
      logic [1:0] idx;
      idx = last + 2'(k);
      if (!gval && rdy[idx]) begin
        gval = 1'b1;
        gidx = idx;
      end
    end
  end

  logic [3:0]    xc;
  logic [DW-1:0] xa, xb, xr;
  logic [DW:0]   sum, diff;
  logic [1:0]    xs;

  assign xc   = pc[gidx];
  assign xa   = pa[gidx];
  assign xb   = pb[gidx];
  assign sum  = {1'b0, xa} + {1'b0, xb};
  assign diff = {1'b0, xa} - {1'b0, xb};

  always_comb begin
    case (xc)
      4'd1:    begin xr = sum[DW-1:0];        xs = sum[DW]  ? 2'd2 : 2'd1; end
      4'd2:    begin xr = diff[DW-1:0];       xs = diff[DW] ? 2'd2 : 2'd1; end
      4'd5:    begin xr = xa << xb[SW-1:0];   xs = 2'd1; end
      4'd6:    begin xr = xa >> xb[SW-1:0];   xs = 2'd1; end
      default: begin xr = '0;                 xs = 2'd3; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 2'(NP - 1);
    else if (gval) last <= gidx;
  end

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign rdy[i] = (st[i] == S_RDY);

    always_ff @(posedge clk) begin
      if (rst) begin
        st[i]    <= S_IDLE;
        pc[i]    <= '0;
        pa[i]    <= '0;
        pb[i]    <= '0;
        rsp_q[i] <= '0;
        res_q[i] <= '0;
      end else begin
        rsp_q[i] <= '0;
        res_q[i] <= '0;
        case (st[i])
          S_IDLE: if (cmd_in[i] != 4'd0) begin
            pc[i] <= cmd_in[i];
            pa[i] <= opd_in[i];
            st[i] <= S_OP2;
          end
          S_OP2: begin
            pb[i] <= opd_in[i];
            st[i] <= S_RDY;
          end
          S_RDY: if (gval && gidx == 2'(i)) begin
            st[i]    <= S_IDLE;
            rsp_q[i] <= xs;
            res_q[i] <= xr;
          end
          default: st[i] <= S_IDLE;
        endcase
      end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (rsp_q[i] != 2'd0) |=> (rsp_q[i] == 2'd0));
    a_r8_quiet_data: assert property (@(posedge clk) disable iff (rst)
      (rsp_q[i] == 2'd0) |-> (res_q[i] == '0));
    a_r9_own_cmd: assert property (@(posedge clk) disable iff (rst)
      (rsp_q[i] != 2'd0) |-> $past(st[i] == S_RDY));
    a_r6_invalid_nodata: assert property (@(posedge clk) disable iff (rst)
      (rsp_q[i] == 2'd3) |-> (res_q[i] == '0));
    a_r11_hold_op: assert property (@(posedge clk) disable iff (rst)
      (st[i] == S_RDY && !(gval && gidx == 2'(i))) |=> (st[i] == S_RDY && $stable(pc[i])));
  end

  a_r10_one_resp: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_q[0] != 2'd0, rsp_q[1] != 2'd0, rsp_q[2] != 2'd0, rsp_q[3] != 2'd0}) <= 1);
  a_r12_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rsp_q[0] == 2'd0 && rsp_q[1] == 2'd0 && rsp_q[2] == 2'd0 && rsp_q[3] == 2'd0));
endmodule

// File: tb/quad_port_calc_tb.sv
module quad_port_calc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  cmd  [4];
  logic [31:0] opnd [4];
  logic [1:0]  rsp  [4];
  logic [31:0] res  [4];
  int checks = 0;
  int fails  = 0;
  int last_g = 3;

  always #10 clk = ~clk;

  quad_port_calc #(.DW(32)) dut_i (
    .clk(clk), .rst(rst),
    .cmd0_i(cmd[0]), .cmd1_i(cmd[1]), .cmd2_i(cmd[2]), .cmd3_i(cmd[3]),
    .opnd0_i(opnd[0]), .opnd1_i(opnd[1]), .opnd2_i(opnd[2]), .opnd3_i(opnd[3]),
    .rsp0_o(rsp[0]), .rsp1_o(rsp[1]), .rsp2_o(rsp[2]), .rsp3_o(rsp[3]),
    .res0_o(res[0]), .res1_o(res[1]), .res2_o(res[2]), .res3_o(res[3])
  );

  function automatic logic [33:0] model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] t;
    case (c)
      4'd0: return {2'd0, 32'd0};
      4'd1: begin t = {1'b0, a} + {1'b0, b}; return {(t > 33'hFFFF_FFFF) ? 2'd2 : 2'd1, t[31:0]}; end
      4'd2: return {(b > a) ? 2'd2 : 2'd1, a - b};
      4'd5: return {2'd1, a << b[4:0]};
      4'd6: return {2'd1, a >> b[4:0]};
      default: return {2'd3, 32'd0};
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c, input logic [1:0] r);
    case (c)
      4'd0: return "R7";
      4'd1: return (r == 2'd2) ? "R2" : "R1";
      4'd2: return (r == 2'd2) ? "R4" : "R3";
      4'd5, 4'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic others_idle(input int p, input string tag);
    for (int q = 0; q < 4; q++)
      if (q != p) chk(rsp[q] == 2'd0 && res[q] == 32'd0, tag, {rsp[q], res[q]}, 64'd0);
  endtask

  task automatic single(input int p, input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [33:0] e;
    string tg;
    e = model(c, a, b);
    tg = tag_of(c, e[33:32]);
    cmd[p] = c; opnd[p] = a;
    @(negedge clk);
    cmd[p] = 4'd0; opnd[p] = b;
    @(negedge clk);
    opnd[p] = 32'd0;
    chk(rsp[p] == 2'd0, "R8", rsp[p], 0);
    @(negedge clk);
    chk(rsp[p] == e[33:32] && res[p] == e[31:0], tg, {rsp[p], res[p]}, e);
    others_idle(p, "R9");
    @(negedge clk);
    chk(rsp[p] == 2'd0 && res[p] == 32'd0, "R8", {rsp[p], res[p]}, 0);
    if (c != 4'd0) last_g = p;
  endtask

  task automatic conc(input logic [3:0] mask, input logic [3:0] c);
    logic [31:0] a [4];
    logic [31:0] b [4];
    int n;
    n = 0;
    for (int q = 0; q < 4; q++) begin
      a[q] = 32'h1000_0000 * (q + 1) + 32'(q);
      b[q] = 32'h0F00_0003 + 32'(q);
      if (mask[q]) begin cmd[q] = c; opnd[q] = a[q]; n++; end
    end
    @(negedge clk);
    for (int q = 0; q < 4; q++) begin cmd[q] = 4'd0; opnd[q] = mask[q] ? b[q] : 32'd0; end
    @(negedge clk);
    for (int q = 0; q < 4; q++) opnd[q] = 32'd0;
    for (int k = 0; k < n; k++) begin
      int w;
      logic [33:0] e;
      @(negedge clk);
      w = last_g;
      for (int s = 1; s <= 4; s++)
        if (w == last_g && mask[(last_g + s) % 4]) w = (last_g + s) % 4;
      e = model(c, a[w], b[w]);
      chk(rsp[w] == e[33:32] && res[w] == e[31:0], "R10", {rsp[w], res[w], 32'(w)}, {e, 32'(w)});
      others_idle(w, "R10");
      last_g = w;
    end
    @(negedge clk);
    others_idle(-1, "R10");
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] pa [7];
    logic [31:0] pb [7];
    pa[0] = 32'h0000_0003; pb[0] = 32'h0000_0004;
    pa[1] = 32'hFFFF_FFFE; pb[1] = 32'h0000_0001;
    pa[2] = 32'hFFFF_FFFF; pb[2] = 32'h0000_0001;
    pa[3] = 32'h8000_0000; pb[3] = 32'h8000_0000;
    pa[4] = 32'h1234_5678; pb[4] = 32'h1234_5678;
    pa[5] = 32'hA5A5_0001; pb[5] = 32'hFFFF_FFE0;
    pa[6] = 32'h0F0F_0F0F; pb[6] = 32'h0000_003F;
    for (int q = 0; q < 4; q++) begin cmd[q] = 4'd0; opnd[q] = 32'd0; end
    repeat (3) @(negedge clk);
    for (int q = 0; q < 4; q++) chk(rsp[q] == 2'd0 && res[q] == 32'd0, "R12", {rsp[q], res[q]}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R12: first round after reset begins at port 0
    conc(4'b1111, 4'd1);

    // R1/R2/R3/R4 named corners on every port
    for (int p = 0; p < 4; p++) begin
      single(p, 4'd1, 32'hFFFF_FFFE, 32'h0000_0001);   // R1 all ones
      single(p, 4'd1, 32'hFFFF_FFFF, 32'h0000_0001);   // R2 over by one
      single(p, 4'd2, 32'h0000_0005, 32'h0000_0005);   // R3 equal
      single(p, 4'd2, 32'h0000_0005, 32'h0000_0006);   // R4 op2 = op1 + 1
      single(p, 4'd5, 32'h0000_0001, 32'h0000_001F);   // R5 by 31
      single(p, 4'd6, 32'h8000_0000, 32'h0000_0000);   // R5 by 0
    end

    // sweep: every port, every code, every operand pair (R1-R7 by tag)
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 16; c++)
        for (int k = 0; k < 7; k++)
          single(p, 4'(c), pa[k], pb[k]);

    // R7: no-op on all ports gives silence
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      others_idle(-1, "R7");
    end

    // R10: round-robin from each starting point
    for (int p = 0; p < 4; p++) begin
      single(p, 4'd1, 32'd1, 32'd2);
      conc(4'b1111, 4'd2);
    end
    single(0, 4'd1, 32'd9, 32'd9);
    conc(4'b0101, 4'd6);
    conc(4'b1010, 4'd9);

    // R11: codes during busy cycles are dropped
    cmd[1] = 4'd1; opnd[1] = 32'h0000_0010;
    @(negedge clk);
    cmd[1] = 4'd2; opnd[1] = 32'h0000_0020;
    @(negedge clk);
    cmd[1] = 4'd5; opnd[1] = 32'h0000_0001;
    @(negedge clk);
    cmd[1] = 4'd0; opnd[1] = 32'd0;
    chk(rsp[1] == 2'd1 && res[1] == 32'h0000_0030, "R11", {rsp[1], res[1]}, {2'd1, 32'h30});
    last_g = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      others_idle(-1, "R11");
    end

    // R12: reset while a command is held
    cmd[2] = 4'd1; opnd[2] = 32'd7;
    @(negedge clk);
    cmd[2] = 4'd0; opnd[2] = 32'd8;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; opnd[2] = 32'd0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      others_idle(-1, "R12");
    end
    last_g = 3;
    conc(4'b0110, 4'd5);
    finish_up();
  end
endmodule